// File: doc/BRIEF.md
# Pre/Post-Trigger Acquisition Buffer Controller

This block stores a stream of packed ADC words into a circular sample memory around a trigger event. Each 64-bit word carries eight consecutive 8-bit samples. After an arm command, the block first writes a programmable number of pre-trigger words. It then waits in an armed state, overwriting the ring, until a word arrives with its trigger flag set. That word becomes the coarse trigger position. The block then writes a programmable number of further words and stops.

The stored record always holds the trigger word with at least two words (sixteen samples) on each side, so a later stage can refine the crossing point. The pre-trigger depth is bounded only by the ring size less the post-trigger length. When the record is complete, the block pulses a done flag. It presents the address of the trigger word, the sample lane of the crossing inside that word, and the address where the record begins. The trigger comparator, interpolation, DMA and display lie outside this block.

Top module: `acq_trigger_buffer`

## Requirements
- R1: After reset, done is low and no memory write is issued, even if valid input words arrive without an arm command.
- R2: An arm command in the idle state starts a record at ring address 0. A word is written only in a cycle where in_valid is high. Each written word goes to the address one above the previous write, modulo DEPTH, and cycles without in_valid advance nothing.
- R3: The programmed lengths are clamped when the block is armed, as follows. The post length is raised to at least 2 and limited to at most DEPTH-3. The pre length is raised to at least 2 and limited to at most DEPTH-1 minus the clamped post length.
- R4: Trigger flags are ignored on every pre-fill word, including the word that completes the pre-fill count. The first eligible word is valid word number pre (counting from 0).
- R5: The first valid word that carries in_trig while armed is the trigger word. Its ring address is reported on trig_addr, and its in_trig_idx (0 to 7) is reported on trig_idx.
- R6: After exactly post further valid words have been written following the trigger word, done goes high for exactly one cycle, in the cycle after the last write.
- R7: start_addr equals trig_addr minus the clamped pre length, modulo DEPTH. The pre+1+post ring entries from start_addr hold the last pre+1+post valid input words, in order.
- R8: From the last post-trigger write until the next arm, no write is issued, and further trigger flags and valid words leave trig_addr, trig_idx and start_addr unchanged. An arm command during a record has no effect.
- R9: While armed, the ring keeps overwriting across the DEPTH wrap, and the record is still reported correctly when it spans the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a record (honoured only when idle) |
| pre_len | input | AW+1 | Requested pre-trigger words |
| post_len | input | AW+1 | Requested post-trigger words |
| in_valid | input | 1 | Input word strobe |
| in_data | input | DATA_W | Packed sample word |
| in_trig | input | 1 | Trigger hit in this word |
| in_trig_idx | input | IW | Sample lane of the hit |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | AW | Memory write address |
| wr_data | output | DATA_W | Memory write data |
| trig_addr | output | AW | Ring address of the trigger word |
| trig_idx | output | IW | Sample lane of the crossing |
| start_addr | output | AW | Ring address of the record's first word |
| done | output | 1 | One-cycle record-complete pulse |

## Verification
Two events can land on the same input word: completion of the pre-fill count and a trigger flag. One trial holds in_trig high on every word, so a trigger is offered on the completing word itself. The bench then expects the trigger word to be the next valid word after it, with trig_addr equal to the clamped pre length. A second collision is a trigger offered in the same cycle that the final post-trigger write finishes, and again after done. That trigger must not move trig_addr or produce a write.

// File: rtl/acq_trigger_buffer.sv
module acq_trigger_buffer #(
  parameter int DATA_W  = 64,
  parameter int SAMPLES = 8,
  parameter int DEPTH   = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm,
  input  logic [$clog2(DEPTH):0]     pre_len,
  input  logic [$clog2(DEPTH):0]     post_len,
  input  logic                       in_valid,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       in_trig,
  input  logic [$clog2(SAMPLES)-1:0] in_trig_idx,
  output logic                       wr_en,
  output logic [$clog2(DEPTH)-1:0]   wr_addr,
  output logic [DATA_W-1:0]          wr_data,
  output logic [$clog2(DEPTH)-1:0]   trig_addr,
  output logic [$clog2(SAMPLES)-1:0] trig_idx,
  output logic [$clog2(DEPTH)-1:0]   start_addr,
  output logic                       done
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = $clog2(SAMPLES);
  localparam logic [AW:0] MIN_LEN  = (AW+1)'(2);
  localparam logic [AW:0] POST_MAX = (AW+1)'(DEPTH - 3);
  localparam logic [AW:0] RING_MAX = (AW+1)'(DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ARMED, S_POST, S_DONE} state_t;
  state_t state;

  logic [AW-1:0] waddr;
  logic [AW:0]   cnt, pre_eff, post_eff, post_c, pre_c, pre_max;

  assign post_c  = (post_len < MIN_LEN) ? MIN_LEN : (post_len > POST_MAX) ? POST_MAX : post_len;
  assign pre_max = RING_MAX - post_c;
  assign pre_c   = (pre_len < MIN_LEN) ? MIN_LEN : (pre_len > pre_max) ? pre_max : pre_len;

  assign wr_en      = in_valid && (state == S_PRE || state == S_ARMED || state == S_POST);
  assign wr_addr    = waddr;
  assign wr_data    = in_data;
  assign done       = (state == S_DONE);
  assign start_addr = trig_addr - pre_eff[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      waddr     <= '0;
      cnt       <= '0;
      pre_eff   <= MIN_LEN;
      post_eff  <= MIN_LEN;
      trig_addr <= '0;
      trig_idx  <= '0;
    end else begin
      case (state)
        S_IDLE: if (arm) begin
          state    <= S_PRE;
          waddr    <= '0;
          cnt      <= '0;
          pre_eff  <= pre_c;
          post_eff <= post_c;
        end
        S_PRE: if (in_valid) begin
          waddr <= waddr + 1'b1;
          cnt   <= cnt + 1'b1;
          if (cnt + 1'b1 == pre_eff) state <= S_ARMED;
        end
        S_ARMED: if (in_valid) begin
          waddr <= waddr + 1'b1;
          if (in_trig) begin
            trig_addr <= waddr;
            trig_idx  <= in_trig_idx;
            cnt       <= '0;
            state     <= S_POST;
          end
        end
        S_POST: if (in_valid) begin
          waddr <= waddr + 1'b1;
          cnt   <= cnt + 1'b1;
          if (cnt + 1'b1 == post_eff) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_write_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> in_valid);
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_addr == $past(wr_addr) + 1'b1);
  p_arm_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && arm) |=> wr_addr == '0);
  p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> (pre_eff >= MIN_LEN && post_eff >= MIN_LEN && pre_eff + post_eff <= RING_MAX));
  p_no_trig_in_prefill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE) |=> state != S_POST);
  p_trig_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARMED && in_valid && in_trig) |=> trig_addr == $past(wr_addr));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_silent_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_DONE) |-> !wr_en);
  p_trig_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_ARMED) |=> $stable(trig_addr) || $past(state) == S_ARMED);
endmodule

// File: tb/acq_trigger_buffer_bench.sv
`timescale 1ns/1ps
module acq_trigger_buffer_bench;
  localparam int D = 256;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0, arm = 0, in_valid = 0, in_trig = 0;
  logic [AW:0] pre_len = 0, post_len = 0;
  logic [63:0] in_data = 0;
  logic [2:0] in_trig_idx = 0;
  logic wr_en, done;
  logic [AW-1:0] wr_addr, trig_addr, start_addr;
  logic [63:0] wr_data;
  logic [2:0] trig_idx;

  acq_trigger_buffer u_acq_trigger_buffer (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] mem [0:D-1];
  logic [63:0] exp_data [0:4095];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int post_clamp(int p);
    return p < 2 ? 2 : (p > D-3 ? D-3 : p);
  endfunction
  function automatic int pre_clamp(int q, int pc);
    return q < 2 ? 2 : (q > D-1-pc ? D-1-pc : q);
  endfunction

  logic s_done, s_wr;
  logic [AW-1:0] s_addr;

  task automatic step(input bit a, input bit v, input bit t, input logic [2:0] ix, input logic [63:0] d);
    @(negedge clk);
    s_done = done;
    arm = a; in_valid = v; in_trig = t; in_trig_idx = ix; in_data = d;
    #1;
    s_wr = wr_en; s_addr = wr_addr;
    if (wr_en) mem[wr_addr] = wr_data;
  endtask

  task automatic run_trial(input int trial, input int pre_in, input int post_in, input int mode);
    int pc, qc, n, k, guard;
    logic [2:0] kidx;
    logic [AW-1:0] ta, sa;
    bit v, t, a, bad;
    logic [63:0] d;
    pc = post_clamp(post_in);
    qc = pre_clamp(pre_in, pc);
    pre_len = pre_in[AW:0]; post_len = post_in[AW:0];
    step(1, 0, 0, 0, 0);
    n = 0; k = -1; guard = 0;
    while (guard < 3000) begin
      guard++;
      v = (mode >= 3) ? 1'b1 : ($urandom % 4 != 0);
      case (mode)
        1: t = 1'b1;
        2: t = (n >= 600);
        default: t = ($urandom % 8 == 0);
      endcase
      a = (mode == 0) && ($urandom % 16 == 0);
      d = {trial[15:0], 16'($urandom), 32'(n)};
      step(a, v, t, 3'($urandom), d);
      chk(!s_done, "R6 early done", s_done, 0);
      chk(s_wr == v, "R2 write only on valid", s_wr, v);
      if (v) begin
        chk(s_addr == AW'(n % D), "R2/R9 address sequence", s_addr, n % D);
        exp_data[n] = d;
        if (k < 0 && n >= qc && t) begin k = n; kidx = in_trig_idx; end
        n++;
        if (k >= 0 && n == k + pc + 1) break;
      end
    end
    step(1'b0, 1'b1, 1'b1, 3'd5, 64'hdead);
    chk(s_done, "R6 done after last post write", s_done, 1);
    chk(!s_wr, "R8 no write after record", s_wr, 0);
    step(1'b0, 1'b1, 1'b1, 3'd6, 64'hbeef);
    chk(!s_done, "R6 done one cycle", s_done, 0);
    chk(!s_wr, "R8 no write while idle", s_wr, 0);
    step(0, 0, 0, 0, 0);
    ta = AW'(k % D);
    sa = AW'((k - qc + D) % D);
    if (mode == 1) chk(k == qc, "R4 trigger on pre-fill word ignored", k, qc);
    chk(trig_addr == ta, "R5 trig_addr", trig_addr, ta);
    chk(trig_idx == kidx, "R5 trig_idx", trig_idx, kidx);
    chk(start_addr == sa, "R7 start_addr (R3 clamp)", start_addr, sa);
    bad = 0;
    for (int j = 0; j <= qc + pc; j++)
      if (!bad && mem[(sa + j) % D] !== exp_data[k - qc + j]) begin
        bad = 1;
        chk(0, "R7 record content", mem[(sa + j) % D], exp_data[k - qc + j]);
      end
    if (!bad) chk(1, "R7 record content", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !wr_en, "R1 reset state", {done, wr_en}, 0);
    rst_n = 1;
    step(0, 1, 1, 0, 64'h1);
    chk(!s_wr, "R1 no write before arm", s_wr, 0);
    step(0, 1, 0, 0, 64'h2);
    chk(!s_wr && !done, "R1 idle silent", {s_wr, done}, 0);
    run_trial(1, 0, 0, 3);        // R3 minimum clamp
    run_trial(2, 300, 300, 3);    // R3 upper clamps
    run_trial(3, 250, 10, 0);     // R3 pre limited, full ring
    run_trial(4, 5, 4, 1);        // R4 collision
    run_trial(5, 40, 30, 2);      // R9 long armed wait across wrap
    run_trial(6, 1, 300, 1);
    for (int i = 0; i < 20; i++)
      run_trial(10 + i, int'($urandom % 300), int'($urandom % 300), int'($urandom % 4));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule